// File: doc/BRIEF.md
# Infrared Pulse Run-Length Sampler

This block watches one infrared receiver line and turns its waveform into a stream of run-length bytes. The line is sampled on a slow tick that is derived from the block clock by one of two ratios. Each byte carries the level of the line in its top bit and, in its low seven bits, the number of ticks that level lasted. A downstream buffer stores the bytes, and software decodes the remote-control frame from them.

A programmable glitch filter removes short spikes before the runs are measured. The line can be inverted so that an active-low receiver still reports a mark as 1. A packet starts at the first mark. It ends when the line stays at space for a programmable number of ticks. At that point the last partial space run is flushed as a byte, and a one-clock packet-end pulse follows.

Top module: `ir_runlen_sampler`

## Requirements
- R1: A sample tick occurs every DIV_LO clocks (default 64) when `div_sel` is 0 and every DIV_HI clocks (default 128) when `div_sel` is 1. All durations are counted in these ticks.
- R2: When a level run ends, the block emits one byte on `rl_byte` with a one-clock `rl_valid`. Bit 7 holds the level (1 = mark, 0 = space) and bits 6:0 hold the run length in ticks.
- R3: When a run reaches 127 ticks, the block emits a byte with duration 127 and keeps counting the same level from zero. A byte with duration 0 is never emitted.
- R4: A level change that lasts fewer than `filt_thr` ticks is ignored, and its ticks count toward the surrounding run. A change that lasts exactly `filt_thr` ticks is accepted. Values of 0 and 1 disable filtering.
- R5: With `invert` = 1, a low input is treated as a mark.
- R6: Inside a packet, a space that lasts (`idle_thr`+1)*IDLE_UNIT ticks (IDLE_UNIT defaults to 128) ends the packet. The remaining space run is emitted as a byte, and `pkt_end` pulses high for one clock on the clock after that byte. Space seen before the first mark of a packet produces no bytes.
- R7: When the idle limit and the 127-tick cap fall on the same tick, the block emits a single byte of duration 127 and then `pkt_end`.
- R8: Bytes and packet ends are produced only while both `glb_en` and `rx_en` are 1. While either is 0, no output is produced and all run state is cleared.
- R9: Out of reset, `rl_valid`, `pkt_end` and `rl_byte` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, the base for the sample tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_in | input | 1 | Raw receiver line, asynchronous |
| glb_en | input | 1 | Global enable |
| rx_en | input | 1 | Receive enable |
| invert | input | 1 | 1: a low line is a mark |
| div_sel | input | 1 | Tick ratio select, 0 = DIV_LO, 1 = DIV_HI |
| filt_thr | input | THR_W | Minimum ticks before a level change is accepted |
| idle_thr | input | IDLE_W | Idle limit N, packet end after (N+1)*IDLE_UNIT space ticks |
| rl_byte | output | 8 | Run byte: level in bit 7, ticks in bits 6:0 |
| rl_valid | output | 1 | One-clock strobe for `rl_byte` |
| pkt_end | output | 1 | One-clock packet-end pulse |

## Verification
Two functions can act on the same tick: idle expiry and the 127-tick run cap. To make them coincide, the bench sets `idle_thr` to 126, which gives an idle limit of 16256 ticks, exactly 128 runs of 127. It then follows a mark with a long space. The scoreboard expects exactly 128 space bytes of duration 127 and then one packet end, with no extra flush byte and no zero-length byte in between. The neighbouring case is also covered: a mark of exactly 127 ticks followed by a change of level, where the cap byte and the change must not produce an empty run.

// File: rtl/irs_pkg.sv
package irs_pkg;
   // Run byte layout: the level sits above the duration field.
   localparam int DUR_W   = 7;
   localparam int BYTE_W  = DUR_W + 1;
   localparam int RUN_MAX = (1 << DUR_W) - 1;

   function automatic logic [BYTE_W-1:0] pack_run(input logic lvl,
                                                  input logic [DUR_W-1:0] dur);
      return {lvl, dur};
   endfunction
endpackage

// File: rtl/irs_tick_gen.sv
module irs_tick_gen #(
   parameter int DIV_LO = 64,
   parameter int DIV_HI = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic div_sel,
   output logic tick
);
   localparam int  CNT_W  = $clog2(DIV_HI);
   localparam bit  POW2   = ((DIV_LO & (DIV_LO - 1)) == 0) && ((DIV_HI & (DIV_HI - 1)) == 0);
   localparam logic [CNT_W-1:0] LO_LIM = CNT_W'(DIV_LO - 1);
   localparam logic [CNT_W-1:0] HI_LIM = CNT_W'(DIV_HI - 1);

   if (DIV_LO < 2) begin : g_bad_lo
      $error("DIV_LO must be at least 2");
   end
   if (DIV_HI < DIV_LO) begin : g_bad_hi
      $error("DIV_HI must not be below DIV_LO");
   end

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] lim;

   assign lim = div_sel ? HI_LIM : LO_LIM;

   if (POW2) begin : g_mask
      // Free-running counter; a tick whenever the selected low bits are all ones.
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   cnt <= '0;
         else if (!en) cnt <= '0;
         else          cnt <= cnt + 1'b1;
      end
      assign tick = en && ((cnt & lim) == lim);
   end else begin : g_cmp
      // Counter wraps at the selected limit.
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          cnt <= '0;
         else if (!en)        cnt <= '0;
         else if (cnt >= lim) cnt <= '0;
         else                 cnt <= cnt + 1'b1;
      end
      assign tick = en && (cnt >= lim);
   end

   AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick); // R1
endmodule

// File: rtl/irs_glitch_filt.sv
module irs_glitch_filt #(
   parameter int THR_W     = 6,
   parameter bit FILTER_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             tick,
   input  logic             ir_raw,
   input  logic             invert,
   input  logic [THR_W-1:0] thr,
   output logic             lvl
);
   logic sync1, sync2;
   logic samp;

   // Two-stage synchronizer for the asynchronous receiver line.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync1 <= 1'b0;
         sync2 <= 1'b0;
      end else begin
         sync1 <= ir_raw;
         sync2 <= sync1;
      end
   end

   assign samp = sync2 ^ invert;

   if (FILTER_EN) begin : g_filter
      logic [THR_W-1:0] cand;
      logic [THR_W:0]   cand_nxt;

      assign cand_nxt = {1'b0, cand} + 1'b1;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lvl  <= 1'b0;
            cand <= '0;
         end else if (!en) begin
            lvl  <= 1'b0;
            cand <= '0;
         end else if (tick) begin
            if (samp == lvl) begin
               cand <= '0;
            end else if (cand_nxt >= {1'b0, thr}) begin
               lvl  <= samp;
               cand <= '0;
            end else begin
               cand <= cand_nxt[THR_W-1:0];
            end
         end
      end
   end else begin : g_bypass
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    lvl <= 1'b0;
         else if (!en)  lvl <= 1'b0;
         else if (tick) lvl <= samp;
      end
   end

   AST_LVL_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(lvl) |-> ($past(tick) || !$past(en))); // R4
endmodule

// File: rtl/irs_run_track.sv
module irs_run_track
   import irs_pkg::*;
#(
   parameter int IDLE_W    = 8,
   parameter int IDLE_UNIT = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              tick,
   input  logic              lvl,
   input  logic [IDLE_W-1:0] idle_thr,
   output logic [BYTE_W-1:0] rl_byte,
   output logic              rl_valid,
   output logic              pkt_end
);
   localparam int IDLE_CW = IDLE_W + $clog2(IDLE_UNIT) + 1;
   localparam logic [DUR_W-1:0] CAP = DUR_W'(RUN_MAX);

   if (IDLE_UNIT < 2) begin : g_bad_unit
      $error("IDLE_UNIT must be at least 2");
   end

   logic               in_pkt;
   logic               cur_lvl;
   logic [DUR_W-1:0]   cnt;
   logic [IDLE_CW-1:0] idle;
   logic               end_pend;

   logic               changed;
   logic               start;
   logic [DUR_W-1:0]   cnt_nxt;
   logic [IDLE_CW-1:0] idle_nxt;
   logic [IDLE_CW-1:0] idle_lim;
   logic               idle_hit;
   logic               emit_old;
   logic               emit_cur;

   always_comb begin
      idle_lim = (IDLE_CW'(idle_thr) + 1'b1) * IDLE_CW'(IDLE_UNIT);
      changed  = (lvl != cur_lvl);
      start    = !in_pkt && lvl;
      cnt_nxt  = changed ? DUR_W'(1) : cnt + 1'b1;
      if (lvl)          idle_nxt = '0;
      else if (changed) idle_nxt = IDLE_CW'(1);
      else              idle_nxt = idle + 1'b1;
      idle_hit = in_pkt && !lvl && (idle_nxt == idle_lim);
      emit_old = in_pkt && changed && (cnt != '0);
      emit_cur = in_pkt && ((cnt_nxt == CAP) || idle_hit);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_pkt   <= 1'b0;
         cur_lvl  <= 1'b0;
         cnt      <= '0;
         idle     <= '0;
         end_pend <= 1'b0;
         rl_valid <= 1'b0;
         rl_byte  <= '0;
         pkt_end  <= 1'b0;
      end else if (!en) begin
         in_pkt   <= 1'b0;
         cur_lvl  <= 1'b0;
         cnt      <= '0;
         idle     <= '0;
         end_pend <= 1'b0;
         rl_valid <= 1'b0;
         pkt_end  <= 1'b0;
      end else begin
         rl_valid <= 1'b0;
         end_pend <= 1'b0;
         pkt_end  <= end_pend;
         if (tick) begin
            if (start) begin
               in_pkt  <= 1'b1;
               cur_lvl <= 1'b1;
               cnt     <= DUR_W'(1);
               idle    <= '0;
            end else if (in_pkt) begin
               rl_valid <= emit_old || emit_cur;
               if (emit_old)      rl_byte <= pack_run(cur_lvl, cnt);
               else if (emit_cur) rl_byte <= pack_run(lvl, cnt_nxt);
               cnt     <= emit_cur ? '0 : cnt_nxt;
               cur_lvl <= lvl;
               idle    <= idle_nxt;
               if (idle_hit) begin
                  in_pkt   <= 1'b0;
                  cur_lvl  <= 1'b0;
                  idle     <= '0;
                  end_pend <= 1'b1;
               end
            end
         end
      end
   end

   AST_NO_EMPTY_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      rl_valid |-> (rl_byte[DUR_W-1:0] != '0)); // R3
   AST_END_AFTER_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_end |-> ($past(rl_valid) && !$past(rl_byte[DUR_W]))); // R6
   AST_END_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_end |=> !pkt_end); // R6
   AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!rl_valid && !pkt_end)); // R8
   AST_VALID_FROM_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      rl_valid |-> $past(tick)); // R2
endmodule

// File: rtl/ir_runlen_sampler.sv
module ir_runlen_sampler #(
   parameter int DIV_LO    = 64,
   parameter int DIV_HI    = 128,
   parameter int THR_W     = 6,
   parameter int IDLE_W    = 8,
   parameter int IDLE_UNIT = 128,
   parameter bit FILTER_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ir_in,
   input  logic              glb_en,
   input  logic              rx_en,
   input  logic              invert,
   input  logic              div_sel,
   input  logic [THR_W-1:0]  filt_thr,
   input  logic [IDLE_W-1:0] idle_thr,
   output logic [7:0]        rl_byte,
   output logic              rl_valid,
   output logic              pkt_end
);
   logic en;
   logic tick;
   logic lvl;

   assign en = glb_en && rx_en;

   irs_tick_gen #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_tick (
      .clk(clk), .rst_n(rst_n), .en(en), .div_sel(div_sel), .tick(tick)
   );

   irs_glitch_filt #(.THR_W(THR_W), .FILTER_EN(FILTER_EN)) u_filt (
      .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .ir_raw(ir_in),
      .invert(invert), .thr(filt_thr), .lvl(lvl)
   );

   irs_run_track #(.IDLE_W(IDLE_W), .IDLE_UNIT(IDLE_UNIT)) u_track (
      .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .lvl(lvl),
      .idle_thr(idle_thr), .rl_byte(rl_byte), .rl_valid(rl_valid),
      .pkt_end(pkt_end)
   );
endmodule

// File: tb/ir_runlen_sampler_tb.sv
module ir_runlen_sampler_tb;
   localparam int DLO = 4;
   localparam int DHI = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ir_in = 1'b0;
   logic       glb_en = 1'b0;
   logic       rx_en = 1'b0;
   logic       invert = 1'b0;
   logic       div_sel = 1'b0;
   logic [5:0] filt_thr = 6'd1;
   logic [7:0] idle_thr = 8'd0;
   logic [7:0] rl_byte;
   logic       rl_valid;
   logic       pkt_end;

   int checks = 0;
   int fails = 0;
   int seen = 0;
   logic [8:0] exp_q[$];
   string tag = "R2";

   always #5 clk = ~clk;

   ir_runlen_sampler #(.DIV_LO(DLO), .DIV_HI(DHI)) u_dut (
      .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .glb_en(glb_en), .rx_en(rx_en),
      .invert(invert), .div_sel(div_sel), .filt_thr(filt_thr),
      .idle_thr(idle_thr), .rl_byte(rl_byte), .rl_valid(rl_valid),
      .pkt_end(pkt_end)
   );

   // Monitor: each produced item is compared with the head of the queue.
   always @(negedge clk) begin
      if (rst_n && (rl_valid || pkt_end)) begin
         logic [8:0] got;
         got = pkt_end ? 9'h100 : {1'b0, rl_byte};
         seen++;
         checks++;
         if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL %s unexpected output act=%h exp=none", tag, got);
         end else begin
            logic [8:0] want;
            want = exp_q.pop_front();
            if (got !== want) begin
               fails++;
               $display("FAIL %s output act=%h exp=%h", tag, got, want);
            end
         end
      end
   end

   task automatic seg(input logic lvl, input int ticks);
      ir_in = lvl;
      repeat (ticks * (div_sel ? DHI : DLO)) @(negedge clk);
   endtask

   task automatic eb(input logic lvl, input int dur);
      exp_q.push_back({1'b0, lvl, 7'(dur)});
   endtask

   task automatic ee();
      exp_q.push_back(9'h100);
   endtask

   task automatic drain(input string name);
      for (int i = 0; i < 4000 && exp_q.size() != 0; i++) @(negedge clk);
      checks++;
      if (exp_q.size() != 0) begin
         fails++;
         $display("FAIL %s %s pending act=%0d exp=0", tag, name, exp_q.size());
      end
      exp_q.delete();
   endtask

   task automatic setup(input logic inv, input logic dsel, input int thr, input int n);
      glb_en = 1'b0;
      rx_en = 1'b0;
      repeat (3) @(negedge clk);
      invert = inv;
      div_sel = dsel;
      filt_thr = 6'(thr);
      idle_thr = 8'(n);
      ir_in = inv;
      repeat (4) @(negedge clk);
      glb_en = 1'b1;
      rx_en = 1'b1;
      repeat (5) @(negedge clk);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      fails++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      checks++;
      if (rl_valid !== 1'b0 || pkt_end !== 1'b0 || rl_byte !== 8'h00) begin
         fails++;
         $display("FAIL R9 reset act=%b%b%h exp=000", rl_valid, pkt_end, rl_byte);
      end
      rst_n = 1'b1;

      // R2 basic runs with idle flush (R6), fast tick
      tag = "R2";
      setup(1'b0, 1'b0, 1, 0);
      seg(0, 20);
      eb(1, 10); eb(0, 5); eb(1, 20); eb(0, 127); eb(0, 1); ee();
      seg(1, 10); seg(0, 5); seg(1, 20); seg(0, 150);
      drain("R2 basic");

      // R3 cap on marks, exact 127 then change
      tag = "R3";
      setup(1'b0, 1'b0, 1, 0);
      eb(1, 127); eb(1, 3); eb(0, 5); eb(1, 127); eb(0, 6); eb(1, 4);
      eb(0, 127); eb(0, 1); ee();
      seg(1, 130); seg(0, 5); seg(1, 127); seg(0, 6); seg(1, 4); seg(0, 150);
      drain("R3 cap");

      // R4 glitch filter, threshold 8
      tag = "R4";
      setup(1'b0, 1'b0, 8, 0);
      eb(1, 23); eb(0, 8); eb(1, 8); eb(0, 127); eb(0, 1); ee();
      seg(1, 10); seg(0, 3); seg(1, 10); seg(0, 8); seg(1, 8);
      seg(0, 20); seg(1, 7); seg(0, 200);
      drain("R4 filter");

      // R5 inverted line
      tag = "R5";
      setup(1'b1, 1'b0, 1, 0);
      eb(1, 12); eb(0, 6); eb(1, 9); eb(0, 127); eb(0, 1); ee();
      seg(0, 12); seg(1, 6); seg(0, 9); seg(1, 150);
      drain("R5 invert");

      // R1 slow tick ratio
      tag = "R1";
      setup(1'b0, 1'b1, 1, 0);
      eb(1, 10); eb(0, 5); eb(1, 3); eb(0, 127); eb(0, 1); ee();
      seg(1, 10); seg(0, 5); seg(1, 3); seg(0, 150);
      drain("R1 slow tick");

      // R6 idle limit N=1 (256 ticks)
      tag = "R6";
      setup(1'b0, 1'b0, 1, 1);
      eb(1, 5); eb(0, 127); eb(0, 127); eb(0, 2); ee();
      seg(0, 10); seg(1, 5); seg(0, 290);
      drain("R6 idle");

      // R8 either enable low: nothing comes out
      tag = "R8";
      setup(1'b0, 1'b0, 1, 0);
      rx_en = 1'b0;
      seen = 0;
      seg(1, 10); seg(0, 150);
      rx_en = 1'b1;
      glb_en = 1'b0;
      seg(1, 10); seg(0, 150);
      checks++;
      if (seen != 0) begin
         fails++;
         $display("FAIL R8 outputs while off act=%0d exp=0", seen);
      end
      glb_en = 1'b1;
      eb(1, 7); eb(0, 127); eb(0, 1); ee();
      seg(0, 5); seg(1, 7); seg(0, 150);
      drain("R8 re-enable");

      // R7 idle expiry on the cap tick: N=126 gives 16256 = 128*127
      tag = "R7";
      setup(1'b0, 1'b0, 1, 126);
      eb(1, 5);
      for (int k = 0; k < 128; k++) eb(0, 127);
      ee();
      seg(1, 5); seg(0, 16300);
      drain("R7 coincide");

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule